// File: doc/BRIEF.md
# Interpolated Quarter-Wave Sine Generator

This block turns an 18-bit phase word into a signed sine sample. Only one quarter of the wave is stored. The block keeps two tables that it computes at elaboration time. The first holds 256 unsigned samples of the first quarter. The second holds the step from each sample to the next. The magnitude is the stored sample plus a linear correction. That correction is the step multiplied by the low phase bits and scaled back down. Folding by quadrant rebuilds the full period.

A caller presents a phase together with a valid strobe, in any cycle. Exactly three cycles later the result appears on the output with its own valid strobe. The first stage reads the tables, the second multiplies, and the third adds and restores the sign. The output is 19-bit two's complement, where 2^18 stands for a sine of 1.

Top module: `sine_quarter_interp`

## Requirements
- R1: The phase word is split into three fields. Bits 17:16 are the quadrant, bits 15:8 the table index and bits 7:0 the interpolation residue. In quadrants 1 and 3 the 16-bit field in bits 15:0 is bit-inverted before the lookup, and in quadrants 2 and 3 the magnitude is negated. So phase 196608 gives -262143.
- R2: Every output is within 4 LSB of 2^18·sin(2π·q/2^18). For quadrants 0 and 2, q is the phase. For quadrants 1 and 3, q is the phase plus one, modulo 2^18.
- R3: The output magnitude never reaches 2^18. Phases 65535 and 65536 both give +262143.
- R4: When phase bit 17 is set, the output is zero or negative.
- R5: Phases 0 and 131072 both give exactly 0.
- R6: The output valid strobe is the input valid strobe delayed by exactly 3 clock cycles. The result that goes with it appears in the same cycle.
- R7: While reset is high, the output valid strobe and the output value are 0. A sample still in the pipeline when reset rises never produces an output valid.
- R8: A new phase is accepted in every cycle. A cycle without input valid produces exactly one cycle without output valid, three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Phase word is valid this cycle |
| phase | input | 18 | Phase word: quadrant, index, residue |
| out_valid | output | 1 | Output sample is valid |
| out_sine | output | 19 | Signed sine sample, 2^18 equals one |

## Verification
Two events can fall in the same cycle. One is a result leaving the last stage. The other is a new phase entering the first stage, or reset clearing the pipeline. The bench streams phases back to back, with scattered idle cycles. In the middle of a stream it raises reset while samples are still in flight. A reference model of a 3-deep shift line, built on real-valued sine, judges every cycle. It predicts both the valid strobe and the value. A sample that leaks out after reset, or a lost or duplicated slot, therefore shows as a strobe mismatch.

// File: rtl/sine_quarter_interp.sv
module sine_quarter_interp #(
  parameter int PW = 18,
  parameter int TW = 18,
  parameter int DW = 11,
  parameter int AW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [PW-1:0]       phase,
  output logic                out_valid,
  output logic signed [TW:0]  out_sine
);
  localparam int FW = PW - 2;
  localparam int RW = FW - AW;
  localparam int NE = 1 << AW;
  localparam int PRW = DW + RW;

  function automatic int quarter_sample(input int k);
    real x, term, acc;
    x = 3.14159265358979323846 * real'(k) / (2.0 * real'(NE));
    term = x;
    acc = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      acc = acc + term;
    end
    return $rtoi(acc * real'(1 << TW) + 0.5);
  endfunction

  logic [TW-1:0] smp_tbl [NE];
  logic [DW-1:0] dif_tbl [NE];

  for (genvar k = 0; k < NE; k++) begin : g_tbl
    localparam int S0 = quarter_sample(k);
    localparam int S1 = quarter_sample(k + 1);
    assign smp_tbl[k] = TW'(S0);
    assign dif_tbl[k] = DW'(S1 - S0);
  end

  wire [FW-1:0] fld = phase[PW-2] ? ~phase[FW-1:0] : phase[FW-1:0];

  logic          v1, v2, n1, n2;
  logic [TW-1:0] s1, s2;
  logic [DW-1:0] d1;
  logic [RW-1:0] r1;
  logic [PRW-1:0] p2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; n1 <= 1'b0; s1 <= '0; d1 <= '0; r1 <= '0;
    end else begin
      v1 <= in_valid;
      n1 <= phase[PW-1];
      s1 <= smp_tbl[fld[FW-1:RW]];
      d1 <= dif_tbl[fld[FW-1:RW]];
      r1 <= fld[RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; n2 <= 1'b0; s2 <= '0; p2 <= '0;
    end else begin
      v2 <= v1;
      n2 <= n1;
      s2 <= s1;
      p2 <= PRW'(d1) * PRW'(r1);
    end
  end

  wire [TW:0] mag = {1'b0, s2} + (TW+1)'(p2[PRW-1:RW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sine  <= '0;
    end else begin
      out_valid <= v2;
      out_sine  <= n2 ? -$signed(mag) : $signed(mag);
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sine != {1'b1, {TW{1'b0}}})); // R3

  AST_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase[PW-1]) |-> ##3 (out_sine[TW] || out_sine == '0)); // R4

  AST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase[PW-2:0] == '0) |-> ##3 (out_sine == '0)); // R5
endmodule

// File: tb/test_sine_quarter_interp.sv
`timescale 1ns/1ps
module test_sine_quarter_interp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [17:0] phase = '0;
  logic out_valid;
  logic signed [18:0] out_sine;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  sine_quarter_interp i_sine_quarter_interp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase),
    .out_valid(out_valid), .out_sine(out_sine)
  );

  always #2 clk = ~clk;

  real eq [3];
  bit  vq [3];

  function automatic real ref_sine(input int p);
    int q;
    q = p;
    if (p[16]) q = (p + 1) % 262144;
    return $sin(2.0 * 3.14159265358979323846 * real'(q) / 262144.0) * 262144.0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin vq[i] = 0; eq[i] = 0.0; end
    end else begin
      vq[2] = vq[1]; eq[2] = eq[1];
      vq[1] = vq[0]; eq[1] = eq[0];
      vq[0] = in_valid; eq[0] = ref_sine(int'(phase));
    end
  end

  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      checks++;
      if (out_valid !== vq[2]) begin
        errors++;
        $display("FAIL R6/R8 valid strobe: actual %0b expected %0b", out_valid, vq[2]);
      end
      if (vq[2]) begin
        real diff;
        checks++;
        diff = real'(out_sine) - eq[2];
        if (diff > 4.0 || diff < -4.0) begin
          errors++;
          $display("FAIL R2 value: actual %0d expected %f", out_sine, eq[2]);
        end
      end
    end
  end

  task automatic check_exact(input int p, input int val, input string tag);
    @(negedge clk);
    in_valid = 1'b1; phase = 18'(p);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (out_sine !== 19'(val) || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s phase %0d: actual %0d expected %0d", tag, p, out_sine, val);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sine !== '0) begin
      errors++;
      $display("FAIL R7 reset state: actual %0b/%0d expected 0/0", out_valid, out_sine);
    end
    rst = 1'b0;

    check_exact(0, 0, "R5");
    check_exact(131072, 0, "R5");
    check_exact(65535, 262143, "R3");
    check_exact(65536, 262143, "R3");
    check_exact(196608, -262143, "R1");

    // R1 R4: boundaries of every quadrant, back to back
    for (int qd = 0; qd < 4; qd++) begin
      for (int o = -3; o <= 3; o++) begin
        @(negedge clk);
        in_valid = 1'b1; phase = 18'((qd * 65536 + o + 262144) % 262144);
      end
    end

    // R7: reset while samples are in flight
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); in_valid = 1'b1; phase = 18'(1000 + i * 5000);
    end
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk) begin
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R7 flushed sample: actual %0b expected 0", out_valid);
      end
    end

    // R2 R8: even phases with idle cycles mixed in
    for (int p = 0; p < 262144; p += 2) begin
      @(negedge clk);
      in_valid = (p % 74) != 36;
      phase = 18'(p);
    end
    // R2: odd phases
    for (int p = 1; p < 262144; p += 97) begin
      @(negedge clk);
      in_valid = 1'b1; phase = 18'(p);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule